// File: doc/BRIEF.md
# Descriptor-Walking Bus Master DMA Engine

This engine moves a block of bytes between a drive-side data buffer and system memory by following a scatter list that software has left in memory. Each list entry is an 8-byte record giving a buffer address, a byte count and an end-of-list marker. On a start pulse, the engine captures the list base pointer, the transfer direction and the number of bytes the drive side wants moved. It then alternates between two steps. It fetches a record through a read port. It issues memory bursts against the buffer that record describes.

The engine stops when the requested byte count is used up, which is a successful completion. It also stops if the list runs out first, or if the list walk has gone one full 4 KiB page past the base. Either of those ends the transfer with an error. Each completion is reported by a one-cycle done pulse, with an error flag alongside it. Every request port carries a valid/ready handshake, and only one request is outstanding at a time. The next request waits for the response to the previous one.

Top module: `prd_dma_engine`

## Requirements
- R1: A descriptor fetch reads 8 bytes at the current list pointer. In the 64-bit response, bits 31:0 are the buffer address and bits 63:32 are the size/flags word.
- R2: The byte count of a descriptor is its size word ANDed with 0xFFFE, so size bit 0 never changes a burst length.
- R3: A masked byte count of zero stands for 65536 bytes.
- R4: Size-word bit 31 (response bit 63) marks the final descriptor. Once that descriptor is used up, no further fetch is made.
- R5: The list pointer grows by 8 after every fetch. Each start reloads the pointer from the base and discards any partly used descriptor, so the first fetch of every transfer is at the base address.
- R6: Each burst covers the smallest of three values: the bytes still requested, the bytes left in the current descriptor, and 4096. The burst address then moves forward by that length within the descriptor buffer.
- R7: When the requested bytes are used up, the engine completes with error_o low and fetches nothing more. A request of zero bytes completes with no fetch and no burst.
- R8: If the final descriptor is used up before the requested byte count, the transfer completes with error_o high.
- R9: No fetch is issued once the list pointer is 4096 or more bytes past the base. Reaching that point completes the transfer with error_o high, so a list with no end marker yields exactly 512 fetches.
- R10: A request is held stable while its ready is low. After a request is accepted, the engine issues nothing further until the matching response arrives.
- R11: done_o is high for exactly one cycle per transfer, and a start pulse that arrives while a transfer is running is ignored.
- R12: mem_we_o equals the to_mem_i value captured at start, with 1 meaning the engine writes memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| to_mem_i | input | 1 | Direction: 1 writes memory, 0 reads memory |
| table_base_i | input | 32 | Descriptor list base address |
| req_bytes_i | input | REQ_W | Byte count requested by the drive side |
| desc_rd_valid_o | output | 1 | Descriptor fetch request valid |
| desc_rd_ready_i | input | 1 | Descriptor fetch request accepted |
| desc_rd_addr_o | output | 32 | Descriptor fetch address |
| desc_rsp_valid_i | input | 1 | Descriptor data valid |
| desc_rsp_data_i | input | 64 | Descriptor data, little-endian |
| mem_valid_o | output | 1 | Memory burst request valid |
| mem_ready_i | input | 1 | Memory burst request accepted |
| mem_addr_o | output | 32 | Burst start address |
| mem_len_o | output | BURST_W | Burst length in bytes |
| mem_we_o | output | 1 | Burst is a memory write |
| mem_done_i | input | 1 | Burst finished |
| done_o | output | 1 | One-cycle completion pulse |
| error_o | output | 1 | Incomplete completion, valid with done_o |

## Verification
The engine takes its decision in a check state that it enters one cycle after start, after a fetch response, or after a burst-done response. done_o and error_o come from registers and rise one cycle after that decision, so a zero-byte request shows done two edges after start is sampled. The bench drives and samples only on falling edges. It polls for done_o on every falling edge and then confirms on the next falling edge that the pulse has dropped. Ready and response latencies are randomized, so the bench does not predict a fixed cycle for each request. Instead it logs every handshake on the falling edge before the edge that accepts it, and compares those logs with the burst and fetch sequences its model computes.

// File: rtl/prd_dma_pkg.sv
package prd_dma_pkg;

   localparam int DESC_BYTES = 8;
   localparam int DLEN_W     = 17;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CHECK,
      ST_FETCH,
      ST_FWAIT,
      ST_BURST,
      ST_BWAIT
   } walk_state_e;

   typedef struct packed {
      logic [31:0]       buf_addr;
      logic [DLEN_W-1:0] len;
      logic              last;
   } prd_desc_t;

endpackage

// File: rtl/prd_desc_decode.sv
module prd_desc_decode
   import prd_dma_pkg::*;
(
   input  logic [63:0] raw_i,
   output prd_desc_t   desc_o
);
   logic [31:0] size_word;
   logic [15:0] masked;

   always_comb begin
      size_word       = raw_i[63:32];
      masked          = {size_word[15:1], 1'b0};
      desc_o.buf_addr = raw_i[31:0];
      desc_o.last     = size_word[31];
      if (masked == 16'd0) desc_o.len = DLEN_W'(17'h10000);
      else                 desc_o.len = DLEN_W'(masked);
   end
endmodule

// File: rtl/prd_step_len.sv
module prd_step_len
   import prd_dma_pkg::*;
#(
   parameter int REQ_W     = 20,
   parameter int BURST_MAX = 4096,
   localparam int BURST_W  = $clog2(BURST_MAX + 1)
)(
   input  logic [REQ_W-1:0]   remain_i,
   input  logic [DLEN_W-1:0]  dlen_i,
   output logic [BURST_W-1:0] step_o
);
   logic [31:0] a, b, m;

   always_comb begin
      a = 32'(remain_i);
      b = 32'(dlen_i);
      m = (a < b) ? a : b;
   end

   generate
      if (BURST_MAX >= 65536) begin : g_nocap
         assign step_o = BURST_W'(m);
      end else begin : g_cap
         assign step_o = (m > 32'(BURST_MAX)) ? BURST_W'(BURST_MAX) : BURST_W'(m);
      end
   endgenerate
endmodule

// File: rtl/prd_table_guard.sv
module prd_table_guard #(
   parameter int TABLE_LIMIT = 4096
)(
   input  logic [31:0] base_i,
   input  logic [31:0] ptr_i,
   output logic        ok_o
);
   logic [31:0] span;
   assign span = ptr_i - base_i;
   assign ok_o = span < 32'(TABLE_LIMIT);
endmodule

// File: rtl/prd_dma_engine.sv
module prd_dma_engine
   import prd_dma_pkg::*;
#(
   parameter int REQ_W       = 20,
   parameter int BURST_MAX   = 4096,
   parameter int TABLE_LIMIT = 4096,
   localparam int BURST_W    = $clog2(BURST_MAX + 1)
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic               to_mem_i,
   input  logic [31:0]        table_base_i,
   input  logic [REQ_W-1:0]   req_bytes_i,
   output logic               desc_rd_valid_o,
   input  logic               desc_rd_ready_i,
   output logic [31:0]        desc_rd_addr_o,
   input  logic               desc_rsp_valid_i,
   input  logic [63:0]        desc_rsp_data_i,
   output logic               mem_valid_o,
   input  logic               mem_ready_i,
   output logic [31:0]        mem_addr_o,
   output logic [BURST_W-1:0] mem_len_o,
   output logic               mem_we_o,
   input  logic               mem_done_i,
   output logic               done_o,
   output logic               error_o
);

   initial begin
      assert (REQ_W >= 1 && REQ_W <= 31) else $error("REQ_W out of range");
      assert (BURST_MAX >= 2 && BURST_MAX % 2 == 0) else $error("BURST_MAX must be even and >= 2");
      assert (TABLE_LIMIT >= DESC_BYTES && TABLE_LIMIT % DESC_BYTES == 0)
         else $error("TABLE_LIMIT must be a multiple of the descriptor size");
   end

   walk_state_e       state;
   logic [31:0]       base_q, cur_ptr, d_addr;
   logic [REQ_W-1:0]  remain;
   logic [DLEN_W-1:0] d_len;
   logic              d_last, dir_q, done_q, err_q;

   prd_desc_t          dec;
   logic [BURST_W-1:0] step;
   logic               window_ok;

   prd_desc_decode u_decode (
      .raw_i  (desc_rsp_data_i),
      .desc_o (dec)
   );

   prd_step_len #(.REQ_W(REQ_W), .BURST_MAX(BURST_MAX)) u_step (
      .remain_i (remain),
      .dlen_i   (d_len),
      .step_o   (step)
   );

   prd_table_guard #(.TABLE_LIMIT(TABLE_LIMIT)) u_guard (
      .base_i (base_q),
      .ptr_i  (cur_ptr),
      .ok_o   (window_ok)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         base_q  <= '0;
         cur_ptr <= '0;
         d_addr  <= '0;
         d_len   <= '0;
         d_last  <= 1'b0;
         remain  <= '0;
         dir_q   <= 1'b0;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         err_q  <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (start_i) begin
                  base_q  <= table_base_i;
                  cur_ptr <= table_base_i;
                  remain  <= req_bytes_i;
                  dir_q   <= to_mem_i;
                  d_len   <= '0;
                  d_addr  <= '0;
                  d_last  <= 1'b0;
                  state   <= ST_CHECK;
               end
            end
            ST_CHECK: begin
               if (remain == '0) begin
                  done_q <= 1'b1;
                  state  <= ST_IDLE;
               end else if (d_len == '0) begin
                  if (d_last || !window_ok) begin
                     done_q <= 1'b1;
                     err_q  <= 1'b1;
                     state  <= ST_IDLE;
                  end else begin
                     state <= ST_FETCH;
                  end
               end else begin
                  state <= ST_BURST;
               end
            end
            ST_FETCH: begin
               if (desc_rd_ready_i) begin
                  cur_ptr <= cur_ptr + 32'(DESC_BYTES);
                  state   <= ST_FWAIT;
               end
            end
            ST_FWAIT: begin
               if (desc_rsp_valid_i) begin
                  d_addr <= dec.buf_addr;
                  d_len  <= dec.len;
                  d_last <= dec.last;
                  state  <= ST_CHECK;
               end
            end
            ST_BURST: begin
               if (mem_ready_i) begin
                  d_addr <= d_addr + 32'(step);
                  d_len  <= d_len - DLEN_W'(step);
                  remain <= remain - REQ_W'(step);
                  state  <= ST_BWAIT;
               end
            end
            ST_BWAIT: begin
               if (mem_done_i) state <= ST_CHECK;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign desc_rd_valid_o = (state == ST_FETCH);
   assign desc_rd_addr_o  = cur_ptr;
   assign mem_valid_o     = (state == ST_BURST);
   assign mem_addr_o      = d_addr;
   assign mem_len_o       = step;
   assign mem_we_o        = dir_q;
   assign done_o          = done_q;
   assign error_o         = err_q;

   assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   assert_error_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
      error_o |-> done_o);

   assert_burst_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid_o |-> (mem_len_o != '0 && 32'(mem_len_o) <= 32'(BURST_MAX)));

   assert_burst_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid_o && !mem_ready_i) |=>
         (mem_valid_o && $stable(mem_addr_o) && $stable(mem_len_o) && $stable(mem_we_o)));

   assert_fetch_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (desc_rd_valid_o && !desc_rd_ready_i) |=> (desc_rd_valid_o && $stable(desc_rd_addr_o)));

   assert_table_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
      desc_rd_valid_o |-> ((desc_rd_addr_o - base_q) < 32'(TABLE_LIMIT)));

   assert_start_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (state != ST_IDLE) |=> $stable(base_q));

   assert_one_request_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_valid_o && desc_rd_valid_o));

endmodule

// File: tb/prd_dma_engine_tb_top.sv
module prd_dma_engine_tb_top;
   localparam int REQ_W   = 20;
   localparam int BURST_W = 13;
   localparam int LOGN    = 1024;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic               start_i = 1'b0, to_mem_i = 1'b0;
   logic [31:0]        table_base_i = '0;
   logic [REQ_W-1:0]   req_bytes_i = '0;
   logic               desc_rd_valid_o, desc_rd_ready_i = 1'b0;
   logic [31:0]        desc_rd_addr_o;
   logic               desc_rsp_valid_i = 1'b0;
   logic [63:0]        desc_rsp_data_i = '0;
   logic               mem_valid_o, mem_ready_i = 1'b0;
   logic [31:0]        mem_addr_o;
   logic [BURST_W-1:0] mem_len_o;
   logic               mem_we_o, mem_done_i = 1'b0;
   logic               done_o, error_o;

   prd_dma_engine dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .to_mem_i(to_mem_i),
      .table_base_i(table_base_i), .req_bytes_i(req_bytes_i),
      .desc_rd_valid_o(desc_rd_valid_o), .desc_rd_ready_i(desc_rd_ready_i),
      .desc_rd_addr_o(desc_rd_addr_o), .desc_rsp_valid_i(desc_rsp_valid_i),
      .desc_rsp_data_i(desc_rsp_data_i), .mem_valid_o(mem_valid_o),
      .mem_ready_i(mem_ready_i), .mem_addr_o(mem_addr_o), .mem_len_o(mem_len_o),
      .mem_we_o(mem_we_o), .mem_done_i(mem_done_i), .done_o(done_o), .error_o(error_o)
   );

   int nvec = 0, nfail = 0;
   logic [63:0] tbl [0:7];
   bit          fill_mode = 1'b0;
   logic [31:0] cur_base = '0;

   logic [31:0] f_log [0:LOGN-1];
   logic [31:0] m_addr [0:LOGN-1];
   int          m_len [0:LOGN-1];
   logic        m_we [0:LOGN-1];
   int          nf_got = 0, nm_got = 0;

   logic [31:0] e_addr [0:LOGN-1];
   int          e_len [0:LOGN-1];
   int          ne = 0, nf_exp = 0;
   bit          e_err = 1'b0;

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      nvec++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   function automatic logic [63:0] desc_at(input logic [31:0] addr);
      int idx;
      idx = int'((addr - cur_base) >> 3);
      if (fill_mode) return {32'h0000_0002, 32'h2000_0000 + 32'(idx * 16)};
      if (idx < 8) return tbl[idx];
      return 64'h0;
   endfunction

   task automatic model(input int req);
      int rem, dl, st;
      logic [31:0] ptr, da;
      logic [63:0] d;
      bit last;
      rem = req; ptr = cur_base; dl = 0; last = 0; da = '0;
      ne = 0; nf_exp = 0; e_err = 0;
      while (1) begin
         if (rem == 0) break;
         if (dl == 0) begin
            if (last || (ptr - cur_base) >= 32'd4096) begin e_err = 1; break; end
            d = desc_at(ptr);
            nf_exp++;
            ptr += 8;
            dl = int'(d[47:32] & 16'hFFFE);
            if (dl == 0) dl = 65536;
            last = d[63];
            da = d[31:0];
         end
         st = rem;
         if (dl < st) st = dl;
         if (st > 4096) st = 4096;
         if (ne < LOGN) begin e_addr[ne] = da; e_len[ne] = st; end
         ne++;
         da += 32'(st); dl -= st; rem -= st;
      end
   endtask

   // descriptor port responder
   initial begin
      int dly;
      bit pend;
      logic [31:0] a;
      pend = 0; dly = 0; a = '0;
      forever begin
         @(negedge clk);
         desc_rsp_valid_i = 1'b0;
         if (desc_rd_ready_i) begin
            desc_rd_ready_i = 1'b0;
            pend = 1; dly = int'($urandom % 3);
         end else if (pend) begin
            if (dly == 0) begin
               desc_rsp_valid_i = 1'b1;
               desc_rsp_data_i = desc_at(a);
               pend = 0;
            end else dly--;
         end else if (desc_rd_valid_o && ($urandom % 2 == 0)) begin
            desc_rd_ready_i = 1'b1;
            a = desc_rd_addr_o;
            if (nf_got < LOGN) f_log[nf_got] = a;
            nf_got++;
         end
      end
   end

   // memory port responder
   initial begin
      int dly;
      bit pend;
      pend = 0; dly = 0;
      forever begin
         @(negedge clk);
         mem_done_i = 1'b0;
         if (mem_ready_i) begin
            mem_ready_i = 1'b0;
            pend = 1; dly = int'($urandom % 3);
         end else if (pend) begin
            if (dly == 0) begin mem_done_i = 1'b1; pend = 0; end
            else dly--;
         end else if (mem_valid_o && ($urandom % 2 == 0)) begin
            mem_ready_i = 1'b1;
            if (nm_got < LOGN) begin
               m_addr[nm_got] = mem_addr_o;
               m_len[nm_got]  = int'(mem_len_o);
               m_we[nm_got]   = mem_we_o;
            end
            nm_got++;
         end
      end
   end

   task automatic run_case(input logic [31:0] base, input int req, input bit dir,
                           input bit mid_start, input string tag);
      bit got, err;
      cur_base = base;
      model(req);
      nf_got = 0; nm_got = 0; got = 0; err = 0;
      @(negedge clk);
      start_i = 1'b1; table_base_i = base; req_bytes_i = REQ_W'(req); to_mem_i = dir;
      @(negedge clk);
      start_i = 1'b0;
      if (mid_start) begin
         repeat (5) @(negedge clk);
         start_i = 1'b1; table_base_i = base + 32'h40; req_bytes_i = REQ_W'(3); to_mem_i = ~dir;
         @(negedge clk);
         start_i = 1'b0;
      end
      for (int c = 0; c < 40000; c++) begin
         @(negedge clk);
         if (done_o) begin got = 1; err = error_o; break; end
      end
      chk(got, {tag, " R11 done seen (watchdog)"}, got, 1);
      @(negedge clk);
      chk(!done_o, {tag, " R11 done single cycle"}, done_o, 0);
      chk(err == e_err, {tag, " R7/R8/R9 error flag"}, err, e_err);
      chk(nf_got == nf_exp, {tag, " R5 fetch count"}, nf_got, nf_exp);
      for (int i = 0; i < nf_got && i < nf_exp && i < LOGN; i++)
         chk(f_log[i] == base + 32'(8 * i), {tag, " R5 fetch address"}, f_log[i], base + 32'(8 * i));
      chk(nm_got == ne, {tag, " R10 burst count"}, nm_got, ne);
      for (int i = 0; i < nm_got && i < ne && i < LOGN; i++) begin
         chk(m_addr[i] == e_addr[i], {tag, " R1/R6 burst address"}, m_addr[i], e_addr[i]);
         chk(m_len[i] == e_len[i], {tag, " R2/R3/R6 burst length"}, m_len[i], e_len[i]);
         chk(m_we[i] == dir, {tag, " R12 direction"}, m_we[i], dir);
      end
   endtask

   task automatic clear_tbl();
      for (int i = 0; i < 8; i++) tbl[i] = 64'h0;
      fill_mode = 1'b0;
   endtask

   initial begin
      int n, total, sz;
      void'($urandom(32'd4242));
      clear_tbl();
      repeat (3) @(negedge clk);
      chk(!done_o && !error_o, "R11 reset done/error low", {done_o, error_o}, 0);
      chk(!mem_valid_o && !desc_rd_valid_o, "R10 reset no requests", {mem_valid_o, desc_rd_valid_o}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 R4 R12: single final descriptor, exact size, memory write
      clear_tbl();
      tbl[0] = {32'h8000_0400, 32'h1234_5670};
      run_case(32'h0001_0000, 32'h400, 1'b1, 1'b0, "single");

      // R2: size bit 0 ignored, table then ends early (R8)
      clear_tbl();
      tbl[0] = {32'h8000_0101, 32'h0000_8000};
      run_case(32'h0002_0000, 32'h200, 1'b0, 1'b0, "bit0");

      // R3: zero count means 65536, split in 4096 bursts (R6)
      clear_tbl();
      tbl[0] = {32'h8000_0000, 32'h0010_0000};
      run_case(32'h0003_0000, 65536, 1'b1, 1'b0, "zero64k");
      run_case(32'h0003_0000, 70000, 1'b0, 1'b0, "zero64k_short");

      // R7: request ends mid-list; rerun from base with held state discarded (R5)
      clear_tbl();
      tbl[0] = {32'h0000_1800, 32'h0040_0000};
      tbl[1] = {32'h0000_0300, 32'h0050_0000};
      tbl[2] = {32'h8000_0100, 32'h0060_0000};
      run_case(32'h0004_0000, 32'h1900, 1'b1, 1'b0, "midlist");
      run_case(32'h0004_0000, 32'h1900, 1'b0, 1'b0, "restart");

      // R8: list ends before request
      run_case(32'h0004_0000, 32'h3000, 1'b1, 1'b0, "short");

      // R7: zero request
      run_case(32'h0004_0000, 0, 1'b1, 1'b0, "zeroreq");

      // R11: start while busy ignored
      run_case(32'h0004_0000, 32'h1b00, 1'b1, 1'b1, "busystart");

      // R9: list with no end marker hits the page stop
      clear_tbl();
      fill_mode = 1'b1;
      run_case(32'h0005_0000, 4000, 1'b0, 1'b0, "pagestop");
      fill_mode = 1'b0;

      // random lists
      for (int t = 0; t < 25; t++) begin
         clear_tbl();
         n = 1 + int'($urandom % 6);
         total = 0;
         for (int i = 0; i < n; i++) begin
            sz = 2 + int'($urandom % 32'h1800);
            tbl[i] = {(i == n - 1) ? 1'b1 : 1'b0, 15'h0, 16'(sz), $urandom};
            total += sz & 16'hFFFE;
         end
         run_case(32'h0010_0000 + 32'(t * 32'h1000), int'($urandom % 32'(total + 32'h400)),
                  1'($urandom), 1'b0, "random");
      end

      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   end
endmodule